// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Access Engine

This block is the slave side of a byte-addressed serial EEPROM on a two-wire bus with a clock line and an open-drain data line. It oversamples both bus lines on the system clock and detects START and STOP conditions. It decodes the 7-bit device type and the direction bit that follows it, and it drives the data line low for acknowledge bits and for zero data bits. Behind it sits a plain synchronous memory port with an address, write data, a write strobe, and read data that appears one cycle after the address.

A word pointer holds the last location touched plus one. The pointer serves three kinds of read. A current read returns the byte at the pointer. A random read is a dummy write of one address byte followed by a repeated START in the read direction. A sequential read streams further bytes for as long as the master acknowledges each one. Writes stream bytes into the array, and the low pointer bits wrap inside a 16-byte page. Two extra device types address neighbouring register spaces. Their contents live elsewhere, but touching them locks out current and sequential reads until a random read reloads the pointer.

Top module: `i2cee_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, `ptr_invalid` is 1 and `alt_lock` is 0.
- R2: The first byte after a START is taken MSB first. Its upper seven bits are the device type and its bit 0 is the direction (1 = read). The EEPROM type is 1010000, and a write-direction byte of that type is acknowledged by pulling SDA low on the ninth clock.
- R3: A random read is a write-direction device byte, one address byte, a repeated START and a read-direction device byte. It returns the byte stored at the address just given and clears `ptr_invalid`.
- R4: A current read returns the byte at n+1, where n is the last address read or written.
- R5: While the master pulls SDA low on the ninth clock of a read byte, the next byte follows from the next address, wrapping from the top of the array to address 0. A high ninth bit ends the transfer, and a STOP then returns the block to idle.
- R6: Written bytes advance only the low four address bits, so they wrap inside a 16-byte page. Twelve bytes written from offset 11 land at offsets 11–15 and then 0–6, leaving offset 7 untouched. The next current read returns offset 7.
- R7: While `ptr_invalid` is 1, a read-direction EEPROM device byte that is not part of a random read gets no acknowledge, and no write strobe is issued.
- R8: Device types 1010111 and 1010010 are acknowledged and set `alt_lock`. While `alt_lock` is 1, current and sequential reads get no acknowledge. A write does not clear the lock.
- R9: A random read clears `alt_lock`, after which current reads work again.
- R10: A device byte of any other type gets no acknowledge and leaves the pointer and both flags unchanged.
- R11: A START in the middle of a byte abandons that byte, and a partly received address byte does not alter the pointer.
- R12: `sda_oe` changes only while SCL is low, except for the release on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| mem_addr | output | ADDR_W | Memory array address (the word pointer) |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| ptr_invalid | output | 1 | 1 while the word pointer has never been loaded |
| alt_lock | output | 1 | 1 after an alternate-space access until a random read |

## Verification
The functions that can meet in one cycle are the page-write commit and the pointer advance. The write strobe lands on the old address, and the page-wrapped increment follows one cycle later. At a page boundary both happen while the pointer wraps. The bench provokes this with a twelve-byte write that crosses offset 15. It judges the result from the memory contents at offsets 15 and 0, from the untouched byte at offset 7, and from the byte returned by the current read that follows. A second collision is a repeated START that arrives while an address byte is only half shifted in. That case is judged by whether the next current read still comes from the old pointer.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_ADR,
      ST_ADR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_SKIP
   } slv_state_e;
endpackage

// File: rtl/i2cee_sync.sv
module i2cee_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cee_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_sh;
   logic [STAGES-1:0] sda_sh;
   logic              scl_d;
   logic              sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_d  <= scl_sh[STAGES-1];
         sda_d  <= sda_sh[STAGES-1];
      end
   end

   assign scl_lvl  = scl_sh[STAGES-1];
   assign sda_lvl  = sda_sh[STAGES-1];
   assign scl_rise = scl_lvl & ~scl_d;
   assign scl_fall = ~scl_lvl & scl_d;
   assign start_p  = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_p   = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2cee_ptr.sv
module i2cee_ptr #(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc_seq,
   input  logic              inc_page,
   input  logic              set_lock,
   input  logic              clr_lock,
   output logic [ADDR_W-1:0] ptr_q,
   output logic              valid_q,
   output logic              lock_q
);
   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
         $error("i2cee_ptr: ADDR_W must be 1..8");
      end
      if (PAGE_W < 0 || PAGE_W > ADDR_W) begin : g_bad_page
         $error("i2cee_ptr: PAGE_W must be 0..ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] seq_next;
   logic [ADDR_W-1:0] page_next;

   assign seq_next = ptr_q + 1'b1;

   generate
      if (PAGE_W > 0 && PAGE_W < ADDR_W) begin : g_page
         logic [PAGE_W-1:0] low_next;
         assign low_next  = ptr_q[PAGE_W-1:0] + 1'b1;
         assign page_next = {ptr_q[ADDR_W-1:PAGE_W], low_next};

         // R6
         page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_page && !load && !inc_seq) |=>
               (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])))
            else $error("page write left its page");
      end else begin : g_flat
         assign page_next = seq_next;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         valid_q <= 1'b0;
         lock_q  <= 1'b0;
      end else begin
         if (load) begin
            ptr_q   <= load_val;
            valid_q <= 1'b1;
         end else if (inc_seq) begin
            ptr_q <= seq_next;
         end else if (inc_page) begin
            ptr_q <= page_next;
         end
         if (set_lock)
            lock_q <= 1'b1;
         else if (clr_lock)
            lock_q <= 1'b0;
      end
   end

   // R7
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> valid_q)
      else $error("pointer became invalid again");
endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave
   import i2cee_pkg::*;
#(
   parameter int         ADDR_W      = 8,
   parameter int         PAGE_W      = 4,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] EE_ID       = 7'b1010000,
   parameter logic [6:0] ALT_ID_A    = 7'b1010111,
   parameter logic [6:0] ALT_ID_B    = 7'b1010010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              ptr_invalid,
   output logic              alt_lock
);
   localparam logic [3:0] BITS_FULL = 4'(BYTE_W);

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_p, stop_p;

   i2cee_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_lvl  (scl_lvl),
      .sda_lvl  (sda_lvl),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_p  (start_p),
      .stop_p   (stop_p)
   );

   slv_state_e        state;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic              sda_oe_q, rw_q, alt_q, addr_loaded, mem_we_q;

   logic [ADDR_W-1:0] ptr_w;
   logic              valid_w, lock_w;
   logic              byte_done, id_ee, id_alt, dev_rd, rd_ok, dev_ack;
   logic              p_load, fetch, set_lock, clr_lock;

   assign byte_done = scl_fall && (bitcnt == BITS_FULL);
   assign dev_rd    = shreg[0];
   assign id_ee     = (shreg[7:1] == EE_ID);
   assign id_alt    = (shreg[7:1] == ALT_ID_A) || (shreg[7:1] == ALT_ID_B);
   assign rd_ok     = addr_loaded || (valid_w && !lock_w);
   assign dev_ack   = id_alt || (id_ee && (!dev_rd || rd_ok));

   always_comb begin
      p_load   = (state == ST_ADR) && byte_done;
      set_lock = (state == ST_DEV) && byte_done && id_alt;
      clr_lock = (state == ST_DEV) && byte_done && id_ee && dev_rd && addr_loaded;
      fetch    = scl_fall && (((state == ST_DEV_ACK) && rw_q && !alt_q) ||
                              (state == ST_RD_ACK));
   end

   i2cee_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (p_load),
      .load_val (shreg[ADDR_W-1:0]),
      .inc_seq  (fetch),
      .inc_page (mem_we_q),
      .set_lock (set_lock),
      .clr_lock (clr_lock),
      .ptr_q    (ptr_w),
      .valid_q  (valid_w),
      .lock_q   (lock_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         bitcnt      <= '0;
         shreg       <= '0;
         sda_oe_q    <= 1'b0;
         rw_q        <= 1'b0;
         alt_q       <= 1'b0;
         addr_loaded <= 1'b0;
         mem_we_q    <= 1'b0;
      end else begin
         mem_we_q <= 1'b0;
         if (start_p) begin
            state    <= ST_DEV;
            bitcnt   <= '0;
            sda_oe_q <= 1'b0;
         end else if (stop_p) begin
            state       <= ST_IDLE;
            sda_oe_q    <= 1'b0;
            addr_loaded <= 1'b0;
         end else if (fetch) begin
            shreg    <= mem_rdata;
            sda_oe_q <= ~mem_rdata[BYTE_W-1];
            bitcnt   <= 4'd1;
            state    <= ST_RD;
         end else begin
            case (state)
               ST_DEV, ST_ADR, ST_WR: begin
                  if (scl_rise && bitcnt != BITS_FULL) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (byte_done) begin
                     bitcnt <= '0;
                     if (state == ST_DEV) begin
                        if (dev_ack) begin
                           sda_oe_q <= 1'b1;
                           rw_q     <= dev_rd;
                           alt_q    <= id_alt;
                           state    <= ST_DEV_ACK;
                           if (id_alt) addr_loaded <= 1'b0;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else if (state == ST_ADR) begin
                        sda_oe_q    <= 1'b1;
                        addr_loaded <= 1'b1;
                        state       <= ST_ADR_ACK;
                     end else begin
                        sda_oe_q    <= 1'b1;
                        mem_we_q    <= 1'b1;
                        addr_loaded <= 1'b0;
                        state       <= ST_WR_ACK;
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (scl_fall) begin
                     sda_oe_q <= 1'b0;
                     state    <= alt_q ? ST_SKIP : ST_ADR;
                  end
               end
               ST_ADR_ACK, ST_WR_ACK: begin
                  if (scl_fall) begin
                     sda_oe_q <= 1'b0;
                     state    <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (bitcnt == BITS_FULL) begin
                        sda_oe_q <= 1'b0;
                        state    <= ST_RD_ACK;
                     end else begin
                        sda_oe_q <= ~shreg[BYTE_W-2];
                        shreg    <= {shreg[BYTE_W-2:0], 1'b1};
                        bitcnt   <= bitcnt + 4'd1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise && sda_lvl) state <= ST_SKIP;
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe      = sda_oe_q;
   assign mem_addr    = ptr_w;
   assign mem_wdata   = shreg;
   assign mem_we      = mem_we_q;
   assign ptr_invalid = ~valid_w;
   assign alt_lock    = lock_w;

   // R12
   drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !$past(scl_lvl))
      else $error("data line pulled while clock high");

   // R7
   write_needs_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !ptr_invalid)
      else $error("write strobe with invalid pointer");

   // R7
   read_needs_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD) |-> valid_w)
      else $error("read data sent from invalid pointer");

   // R8
   locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_DEV_ACK) && rw_q && !alt_q) |-> !lock_w)
      else $error("read acknowledged while locked");

   // R6
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we)
      else $error("write strobe longer than one cycle");
endmodule

// File: tb/i2cee_slave_bench.sv
module i2cee_slave_bench;
   localparam int         HP  = 12;
   localparam int         QP  = 3;
   localparam logic [6:0] EE  = 7'b1010000;
   localparam logic [6:0] AL1 = 7'b1010111;
   localparam logic [6:0] AL2 = 7'b1010010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       sda_line;
   logic       sda_oe, mem_we, ptr_invalid, alt_lock;
   logic [7:0] mem_addr, mem_wdata, mem_rdata;
   logic [7:0] mem [256];
   logic [7:0] exp_mem [256];

   int n_chk = 0;
   int n_fail = 0;
   int viol = 0;
   logic prev_oe = 1'b0;
   logic prev_scl = 1'b1;

   assign sda_line = m_sda & ~sda_oe;

   i2cee_slave u_i2cee_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda_line),
      .sda_oe      (sda_oe),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_we      (mem_we),
      .mem_rdata   (mem_rdata),
      .ptr_invalid (ptr_invalid),
      .alt_lock    (alt_lock)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
      end else if (mem_we) begin
         mem[mem_addr] <= mem_wdata;
      end
      mem_rdata <= mem[mem_addr];
   end

   // R12 monitor: drive level must not move while SCL stays high
   always @(negedge clk) begin
      if (rst_n && (sda_oe !== prev_oe) && scl && prev_scl) viol++;
      prev_oe  <= sda_oe;
      prev_scl <= scl;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hw(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      if (scl == 1'b0) begin
         m_sda = 1'b1; hw(HP);
         scl = 1'b1;   hw(HP);
      end
      m_sda = 1'b0; hw(HP);
      scl = 1'b0;   hw(QP);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; hw(HP);
      scl = 1'b1;   hw(HP);
      m_sda = 1'b1; hw(HP);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         m_sda = b[7-i]; hw(HP);
         scl = 1'b1;     hw(HP);
         scl = 1'b0;     hw(QP);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      m_sda = 1'b1; hw(HP);
      scl = 1'b1;   hw(HP/2);
      ack = ~sda_line;
      hw(HP/2);
      scl = 1'b0;   hw(QP);
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit mack);
      for (int i = 0; i < 8; i++) begin
         hw(HP);
         scl = 1'b1; hw(HP/2);
         b[7-i] = sda_line;
         hw(HP/2);
         scl = 1'b0; hw(QP);
      end
      m_sda = mack ? 1'b0 : 1'b1; hw(HP);
      scl = 1'b1; hw(HP);
      scl = 1'b0; hw(QP);
      m_sda = 1'b1;
   endtask

   // read nb bytes, optionally after a dummy-write address load
   task automatic rd_seq(input bit with_addr, input int addr, input int nb,
                         input int first, input bit exp_ack, input string req);
      logic a;
      logic [7:0] d;
      bus_start();
      if (with_addr) begin
         send_byte({EE, 1'b0}, a);
         check(a == 1'b1, "R2", a, 1);
         send_byte(8'(addr), a);
         check(a == 1'b1, req, a, 1);
         bus_start();
      end
      send_byte({EE, 1'b1}, a);
      check(a == exp_ack, req, a, exp_ack);
      if (a) begin
         for (int k = 0; k < nb; k++) begin
            recv_byte(d, k != nb - 1);
            check(d == exp_mem[(first + k) & 255], req, d, exp_mem[(first + k) & 255]);
         end
      end
      bus_stop();
   endtask

   task automatic wr_page(input int addr, input int nb, input logic [7:0] base);
      logic a;
      bus_start();
      send_byte({EE, 1'b0}, a);
      check(a == 1'b1, "R2", a, 1);
      send_byte(8'(addr), a);
      check(a == 1'b1, "R6", a, 1);
      for (int k = 0; k < nb; k++) begin
         send_byte(base + 8'(k), a);
         check(a == 1'b1, "R6", a, 1);
         exp_mem[(addr & 8'hF0) | ((addr + k) & 8'h0F)] = base + 8'(k);
      end
      bus_stop();
   endtask

   task automatic alt_touch(input logic [6:0] id);
      logic a;
      bus_start();
      send_byte({id, 1'b0}, a);
      check(a == 1'b1, "R8 alt ack", a, 1);
      send_byte(8'h3C, a);
      bus_stop();
      check(alt_lock == 1'b1, "R8 lock set", alt_lock, 1);
   endtask

   task automatic t_reset();
      check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
      check(ptr_invalid == 1'b1, "R1 ptr_invalid", ptr_invalid, 1);
      check(alt_lock == 1'b0, "R1 alt_lock", alt_lock, 0);
   endtask

   task automatic t_invalid_read();
      rd_seq(0, 0, 1, 0, 0, "R7 invalid read nack");
      check(ptr_invalid == 1'b1, "R7 still invalid", ptr_invalid, 1);
   endtask

   task automatic t_random_then_current();
      rd_seq(1, 8'h20, 1, 8'h20, 1, "R3 random read");
      check(ptr_invalid == 1'b0, "R3 ptr valid", ptr_invalid, 0);
      rd_seq(0, 0, 1, 8'h21, 1, "R4 current read n+1");
      rd_seq(0, 0, 3, 8'h22, 1, "R5 sequential read");
   endtask

   task automatic t_page_write();
      wr_page(8'h3B, 12, 8'h60);
      check(mem[8'h3F] == 8'h64, "R6 offset 15", mem[8'h3F], 8'h64);
      check(mem[8'h30] == 8'h65, "R6 wrapped to offset 0", mem[8'h30], 8'h65);
      check(mem[8'h36] == 8'h6B, "R6 offset 6", mem[8'h36], 8'h6B);
      check(mem[8'h37] == (8'h37 ^ 8'hA5), "R6 offset 7 untouched", mem[8'h37], 8'h37 ^ 8'hA5);
      check(mem[8'h40] == (8'h40 ^ 8'hA5), "R6 next page untouched", mem[8'h40], 8'h40 ^ 8'hA5);
      rd_seq(0, 0, 1, 8'h37, 1, "R6 pointer ends at offset 7");
   endtask

   task automatic t_nomatch();
      logic a;
      bus_start();
      send_byte({7'h33, 1'b1}, a);
      check(a == 1'b0, "R10 foreign type nack", a, 0);
      bus_stop();
      check(alt_lock == 1'b0, "R10 lock unchanged", alt_lock, 0);
      rd_seq(0, 0, 1, 8'h38, 1, "R10 pointer unchanged");
   endtask

   task automatic t_lock();
      alt_touch(AL1);
      rd_seq(0, 0, 1, 0, 0, "R8 current read locked");
      rd_seq(1, 8'h10, 2, 8'h10, 1, "R9 random read while locked");
      check(alt_lock == 1'b0, "R9 lock cleared", alt_lock, 0);
      rd_seq(0, 0, 1, 8'h12, 1, "R9 current read restored");
      alt_touch(AL2);
      wr_page(8'h50, 1, 8'h77);
      check(mem[8'h50] == 8'h77, "R8 write while locked", mem[8'h50], 8'h77);
      check(alt_lock == 1'b1, "R8 write keeps lock", alt_lock, 1);
      rd_seq(0, 0, 1, 0, 0, "R8 current read still locked");
   endtask

   task automatic t_wrap_read();
      rd_seq(1, 8'hFE, 3, 8'hFE, 1, "R5 array wrap");
   endtask

   task automatic t_abort();
      logic a;
      logic [7:0] d;
      bus_start();
      send_byte({EE, 1'b0}, a);
      check(a == 1'b1, "R11 device ack", a, 1);
      send_bits(8'h80, 4);
      bus_start();
      send_byte({EE, 1'b1}, a);
      check(a == 1'b1, "R11 read ack", a, 1);
      if (a) begin
         recv_byte(d, 1'b0);
         check(d == exp_mem[1], "R11 pointer kept", d, exp_mem[1]);
      end
      bus_stop();
   endtask

   initial begin
      for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'hA5;
      hw(5);
      rst_n = 1'b1;
      hw(5);
      t_reset();
      t_invalid_read();
      t_random_then_current();
      t_page_write();
      t_nomatch();
      t_lock();
      t_wrap_read();
      t_abort();
      check(viol == 0, "R12 drive changes only with SCL low", viol, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule